// File: doc/BRIEF.md
# Serial Link Power State Controller

This block governs the power state of one end of a point-to-point serial link. From the attached device's power state and the traffic conditions at the transmitter, it selects one of six link states, and a seventh internal exit state covers the latency of returning to full operation. Only the fully active state may carry packets. Two light standby states keep main power and clocks. A one-cycle staging state leads into the two deep states, where clocks are gated and main power is released.

The transmitter drops into its quick standby state on its own, with no handshake from the far end. This happens after a programmable run of idle cycles. The deeper standby state is allowed only while the device is out of its fully-on state. The staging and deep states are allowed only when the device is in its lowest state and a system sleep is requested. If auxiliary power is present, the link parks in an aux-powered state that a wake or beacon input can revive. Otherwise it goes to the zero-power state and stays there until reset. Each return to the active state counts down its own latency before the packet-transmit enable comes back.

Top module: `lpm_link_ctrl`

## Requirements
- R1: During and right after reset, `link_state` is 0 (active), `tx_en` is 1, and `clk_gate` and `pwr_off_req` are 0. The `link_state` codes are: 0 active, 1 quick standby, 2 deep standby, 3 staging, 4 aux-powered off, 5 zero-power off, 6 exiting.
- R2: `tx_en` is 1 only while `link_state` is 0. It is 0 in every other state, including the exit state.
- R3: A cycle is idle when `tx_idle`=1 and `pkt_pend`=0. In state 0 with `dev_pwr`=0, the `idle_limit`-th consecutive idle cycle moves the link to state 1. A non-idle cycle restarts the count. An `idle_limit` of 0 turns off automatic entry.
- R4: In state 1, a non-idle cycle, `sleep_req`=1 or `dev_pwr`≠0 moves the link to state 6. The link then stays in state 6 for exactly L0S_EXIT cycles before it returns to state 0.
- R5: In state 0, an idle cycle with `dev_pwr`≠0 (device states 1 to 3) moves the link to state 2 on the next cycle. With `dev_pwr`=0 the link never enters state 2.
- R6: In state 2, a non-idle cycle, `dev_pwr` returning to 0, or `sleep_req`=1 with `dev_pwr`=3 moves the link to state 6. The link stays there for exactly L1_EXIT cycles, then returns to state 0.
- R7: In state 0, `sleep_req`=1 with `dev_pwr`=3 moves the link to state 3 on the next cycle. This takes priority over entry to state 2. With `dev_pwr`≠3, `sleep_req` does not lead to state 3.
- R8: State 3 lasts exactly one cycle. It is followed by state 4 when `aux_ok`=1 and by state 5 when `aux_ok`=0.
- R9: `clk_gate` and `pwr_off_req` are 1 in states 4 and 5, and 0 in every other state.
- R10: In state 4, `wake_in`=1 moves the link to state 6 for exactly DEEP_EXIT cycles, then to state 0. State 5 ignores `wake_in` and is left only by reset.
- R11: `wake_in` has no effect in states 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_pwr | input | 2 | Device power state, 0 = fully on, 3 = lowest |
| tx_idle | input | 1 | Transmitter has nothing in flight |
| pkt_pend | input | 1 | A packet is waiting to be sent |
| sleep_req | input | 1 | System sleep request |
| aux_ok | input | 1 | Auxiliary power present |
| wake_in | input | 1 | Wake or beacon indication |
| idle_limit | input | IDLE_W | Idle cycles before quick standby, 0 = off |
| link_state | output | 3 | Current link state code |
| tx_en | output | 1 | Packets may be transmitted |
| clk_gate | output | 1 | Link clocks are gated |
| pwr_off_req | output | 1 | Request removal of main power |

## Verification
The bench builds the block with IDLE_W=4 and exit counts of 2, 6 and 9 cycles. A 4-bit idle threshold lets every nonzero `idle_limit` from 1 to 15 be swept, and the bench checks the exact entry cycle and the full exit window each time. The short exit counts keep every exit window small enough to check cycle by cycle. Each device state from 1 to 3 is paired with a different exit cause from deep standby. Both values of `aux_ok` are driven through the staging state.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_L0   = 3'd0,
    ST_L0S  = 3'd1,
    ST_L1   = 3'd2,
    ST_L23R = 3'd3,
    ST_L2   = 3'd4,
    ST_L3   = 3'd5,
    ST_WAKE = 3'd6
  } link_st_e;

  localparam logic [1:0] DEV_D0 = 2'd0;
  localparam logic [1:0] DEV_D3 = 2'd3;

  // A cycle counts as idle when nothing is in flight and nothing waits.
  function automatic logic link_idle(input logic tx_idle, input logic pkt_pend);
    return tx_idle & ~pkt_pend;
  endfunction

  // Packets are allowed in the fully active state only.
  function automatic logic st_may_send(input link_st_e s);
    return s == ST_L0;
  endfunction

  // Clocks and main power are withdrawn only in the two deep states.
  function automatic logic st_unpowered(input link_st_e s);
    return (s == ST_L2) || (s == ST_L3);
  endfunction

  // Bits needed to hold (largest exit count - 1).
  function automatic int exit_cnt_width(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/lpm_idle_timer.sv
module lpm_idle_timer #(
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en,
  input  logic              idle,
  input  logic [IDLE_W-1:0] limit,
  output logic              expire
);
  localparam logic [IDLE_W-1:0] ONE = IDLE_W'(1);

  logic [IDLE_W-1:0] run_q;
  logic              armed;

  assign armed  = limit != '0;
  assign expire = count_en & idle & armed & (run_q == (limit - ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (!count_en || !idle) run_q <= '0;
    else if (run_q != '1)       run_q <= run_q + ONE;
  end

  // R3: above a limit of one, expiry needs an idle cycle just before it
  assert_idle_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && limit > ONE) |-> $past(idle && count_en));

endmodule

// File: rtl/lpm_exit_timer.sv
module lpm_exit_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign done = cnt_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int L0S_EXIT  = 4,
  parameter int L1_EXIT   = 24,
  parameter int DEEP_EXIT = 64,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       dev_pwr,
  input  logic             idle,
  input  logic             sleep_req,
  input  logic             aux_ok,
  input  logic             wake_in,
  input  logic             idle_expire,
  input  logic             exit_done,
  output link_st_e         state_q,
  output logic             exit_load,
  output logic [CNT_W-1:0] exit_val,
  output logic             exit_run
);
  // Exit timer preset: the exit state lasts exactly cyc cycles.
  function automatic logic [CNT_W-1:0] exit_preset(input int cyc);
    return CNT_W'(cyc - 1);
  endfunction

  localparam logic [CNT_W-1:0] P_L0S  = exit_preset(L0S_EXIT);
  localparam logic [CNT_W-1:0] P_L1   = exit_preset(L1_EXIT);
  localparam logic [CNT_W-1:0] P_DEEP = exit_preset(DEEP_EXIT);

  link_st_e nxt;
  logic     sleep_ok;
  logic     dev_on;

  assign sleep_ok = sleep_req && (dev_pwr == DEV_D3);
  assign dev_on   = dev_pwr == DEV_D0;
  assign exit_run = state_q == ST_WAKE;

  always_comb begin
    nxt       = state_q;
    exit_load = 1'b0;
    exit_val  = '0;
    unique case (state_q)
      ST_L0: begin
        if (sleep_ok)              nxt = ST_L23R;
        else if (!dev_on && idle)  nxt = ST_L1;
        else if (idle_expire)      nxt = ST_L0S;
      end
      ST_L0S: begin
        if (!idle || sleep_req || !dev_on) begin
          nxt       = ST_WAKE;
          exit_load = 1'b1;
          exit_val  = P_L0S;
        end
      end
      ST_L1: begin
        if (!idle || dev_on || sleep_ok) begin
          nxt       = ST_WAKE;
          exit_load = 1'b1;
          exit_val  = P_L1;
        end
      end
      ST_L23R: nxt = aux_ok ? ST_L2 : ST_L3;
      ST_L2: begin
        if (wake_in) begin
          nxt       = ST_WAKE;
          exit_load = 1'b1;
          exit_val  = P_DEEP;
        end
      end
      ST_L3:   nxt = ST_L3;
      ST_WAKE: if (exit_done) nxt = ST_L0;
      default: nxt = ST_L0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_L0;
    else        state_q <= nxt;
  end

  // R5: deep standby is entered from active only with the device not fully on
  assert_l1_dev_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_L1 && $past(state_q) == ST_L0) |-> $past(dev_pwr) != DEV_D0);

  // R7: staging is entered only on a sleep request with the device in its lowest state
  assert_stage_d3_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_L23R && $past(state_q) != ST_L23R)
      |-> ($past(dev_pwr) == DEV_D3 && $past(sleep_req)));

  // R8: the deep states are reached only through staging
  assert_deep_via_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_L2 || state_q == ST_L3) && $past(state_q) != state_q)
      |-> $past(state_q) == ST_L23R);

  // R10: the zero-power state is left only by reset
  assert_l3_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_L3) |=> (state_q == ST_L3));

  // R4: the exit state is held until its latency count has run out
  assert_wake_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE && !exit_done) |=> (state_q == ST_WAKE));

endmodule

// File: rtl/lpm_link_ctrl.sv
module lpm_link_ctrl
  import lpm_pkg::*;
#(
  parameter int IDLE_W    = 8,
  parameter int L0S_EXIT  = 4,
  parameter int L1_EXIT   = 24,
  parameter int DEEP_EXIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        dev_pwr,
  input  logic              tx_idle,
  input  logic              pkt_pend,
  input  logic              sleep_req,
  input  logic              aux_ok,
  input  logic              wake_in,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic [2:0]        link_state,
  output logic              tx_en,
  output logic              clk_gate,
  output logic              pwr_off_req
);
  localparam int CNT_W = exit_cnt_width(L0S_EXIT, L1_EXIT, DEEP_EXIT);

  link_st_e         state_q;
  logic             idle_now;
  logic             idle_expire;
  logic             exit_load;
  logic [CNT_W-1:0] exit_val;
  logic             exit_run;
  logic             exit_done;
  logic             in_active;

  assign idle_now  = link_idle(tx_idle, pkt_pend);
  assign in_active = state_q == ST_L0;

  lpm_idle_timer #(.IDLE_W(IDLE_W)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (in_active),
    .idle     (idle_now),
    .limit    (idle_limit),
    .expire   (idle_expire)
  );

  lpm_exit_timer #(.CNT_W(CNT_W)) u_exit (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (exit_load),
    .load_val (exit_val),
    .run      (exit_run),
    .done     (exit_done)
  );

  lpm_fsm #(
    .L0S_EXIT  (L0S_EXIT),
    .L1_EXIT   (L1_EXIT),
    .DEEP_EXIT (DEEP_EXIT),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_pwr     (dev_pwr),
    .idle        (idle_now),
    .sleep_req   (sleep_req),
    .aux_ok      (aux_ok),
    .wake_in     (wake_in),
    .idle_expire (idle_expire),
    .exit_done   (exit_done),
    .state_q     (state_q),
    .exit_load   (exit_load),
    .exit_val    (exit_val),
    .exit_run    (exit_run)
  );

  assign link_state  = state_q;
  assign tx_en       = st_may_send(state_q);
  assign clk_gate    = st_unpowered(state_q);
  assign pwr_off_req = st_unpowered(state_q);

  // R2: transmit enable comes back only at the end of an exit window
  assert_tx_after_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(state_q) == ST_WAKE);

  // R9: power is released only after clocks are gated in the same state
  assert_pwr_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_req |-> (clk_gate && !tx_en));

endmodule

// File: tb/test_lpm_link_ctrl.sv
module test_lpm_link_ctrl;
  localparam int TB_IDLE_W = 4;
  localparam int TB_L0S    = 2;
  localparam int TB_L1     = 6;
  localparam int TB_DEEP   = 9;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [1:0]           dev_pwr;
  logic                 tx_idle, pkt_pend, sleep_req, aux_ok, wake_in;
  logic [TB_IDLE_W-1:0] idle_limit;
  logic [2:0]           link_state;
  logic                 tx_en, clk_gate, pwr_off_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  lpm_link_ctrl #(
    .IDLE_W(TB_IDLE_W), .L0S_EXIT(TB_L0S), .L1_EXIT(TB_L1), .DEEP_EXIT(TB_DEEP)
  ) i_lpm_link_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_pwr(dev_pwr), .tx_idle(tx_idle),
    .pkt_pend(pkt_pend), .sleep_req(sleep_req), .aux_ok(aux_ok),
    .wake_in(wake_in), .idle_limit(idle_limit), .link_state(link_state),
    .tx_en(tx_en), .clk_gate(clk_gate), .pwr_off_req(pwr_off_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    dev_pwr = 2'd0; tx_idle = 1'b0; pkt_pend = 1'b0; sleep_req = 1'b0;
    aux_ok = 1'b0; wake_in = 1'b0; idle_limit = '0;
    step(2);
    rst_n = 1'b1;
  endtask

  // expects the exit state for n cycles after the trigger edge, then active
  task automatic expect_exit(input string tag, input int n);
    for (int k = 1; k < n; k++) begin
      step(1);
      check({tag, " exit hold"}, link_state, 6);
      check("R2 tx_en low in exit", tx_en, 0);
    end
    step(1);
    check({tag, " exit done"}, link_state, 0);
    check("R2 tx_en back in active", tx_en, 1);
  endtask

  initial begin
    do_reset();
    check("R1 reset state", link_state, 0);
    check("R1 reset tx_en", tx_en, 1);
    check("R1 reset clk_gate", clk_gate, 0);
    check("R1 reset pwr_off_req", pwr_off_req, 0);

    // R3/R4: every nonzero idle limit
    for (int lim = 1; lim < 16; lim++) begin
      do_reset();
      idle_limit = TB_IDLE_W'(lim);
      tx_idle = 1'b1;
      if (lim > 1) begin
        step(lim - 1);
        check("R3 before limit", link_state, 0);
      end
      step(1);
      check("R3 at limit", link_state, 1);
      check("R2 tx_en low in standby", tx_en, 0);
      check("R9 no gating in standby", clk_gate, 0);
      pkt_pend = 1'b1;
      step(1);
      check("R4 exit start", link_state, 6);
      expect_exit("R4", TB_L0S);
    end

    // R3: a busy cycle restarts the count
    do_reset();
    idle_limit = 4'd5; tx_idle = 1'b1;
    step(3); tx_idle = 1'b0; step(1); tx_idle = 1'b1;
    step(4);
    check("R3 restart not yet", link_state, 0);
    step(1);
    check("R3 restart reached", link_state, 1);
    // R11: wake has no effect in quick standby
    wake_in = 1'b1;
    step(5);
    check("R11 wake ignored in standby", link_state, 1);

    // R3/R5: limit 0 disables, and device on never enters deep standby
    do_reset();
    tx_idle = 1'b1;
    step(40);
    check("R3 limit zero stays active", link_state, 0);
    check("R5 device on never deep standby", tx_en, 1);

    // R5/R6/R11: device states 1..3, each with a different exit cause
    for (int d = 1; d < 4; d++) begin
      do_reset();
      dev_pwr = 2'(d); tx_idle = 1'b1;
      step(1);
      check("R5 deep standby entry", link_state, 2);
      check("R9 clocks kept in deep standby", clk_gate, 0);
      check("R9 power kept in deep standby", pwr_off_req, 0);
      wake_in = 1'b1;
      step(3);
      check("R11 wake ignored in deep standby", link_state, 2);
      wake_in = 1'b0;
      if (d == 1)      pkt_pend = 1'b1;
      else if (d == 2) dev_pwr = 2'd0;
      else             tx_idle = 1'b0;
      step(1);
      check("R6 exit start", link_state, 6);
      expect_exit("R6", TB_L1);
    end

    // R4/R7: leaving quick standby on a sleep request, then staging
    do_reset();
    idle_limit = 4'd2; tx_idle = 1'b1;
    step(2);
    check("R3 standby before sleep", link_state, 1);
    dev_pwr = 2'd3; sleep_req = 1'b1;
    step(1);
    check("R4 exit on sleep", link_state, 6);
    expect_exit("R4", TB_L0S);
    step(1);
    check("R7 staging after exit", link_state, 3);

    // R7/R8/R9/R10: sleep path with and without aux power
    for (int a = 0; a < 2; a++) begin
      do_reset();
      sleep_req = 1'b1;
      step(5);
      check("R7 sleep ignored with device on", link_state, 0);
      dev_pwr = 2'd1;
      step(5);
      check("R7 sleep ignored in device state 1", link_state, 0);
      dev_pwr = 2'd3; tx_idle = 1'b1; aux_ok = a[0];
      step(1);
      check("R7 staging over deep standby", link_state, 3);
      check("R9 no gating in staging", clk_gate, 0);
      check("R9 power kept in staging", pwr_off_req, 0);
      check("R2 tx_en low in staging", tx_en, 0);
      step(1);
      check("R8 deep state by aux", link_state, (a == 1) ? 4 : 5);
      check("R9 gating in deep", clk_gate, 1);
      check("R9 power off in deep", pwr_off_req, 1);
      step(5);
      check("R8 deep state held", link_state, (a == 1) ? 4 : 5);
      if (a == 1) begin
        sleep_req = 1'b0; dev_pwr = 2'd0; wake_in = 1'b1;
        step(1);
        check("R10 wake from aux state", link_state, 6);
        check("R9 power back in exit", pwr_off_req, 0);
        wake_in = 1'b0;
        expect_exit("R10", TB_DEEP);
      end else begin
        sleep_req = 1'b0; dev_pwr = 2'd0; wake_in = 1'b1;
        step(20);
        check("R10 zero power ignores wake", link_state, 5);
        check("R9 power stays off", pwr_off_req, 1);
      end
    end

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule